// File: doc/BRIEF.md
# Dynamic Phase Shift Sequencer

This block turns one phase-shift request into a run of single-step handshakes toward a PLL's phase-adjust port. A request word carries three fields: a step count, a counter select and a direction. For every step the block raises a phase-enable strobe and holds it for a minimum number of scan-clock cycles. It keeps it high until the PLL's completion flag has dropped. It then waits for that flag to come back high before the next strobe. The counter select and the direction are placed on their outputs one cycle before the first strobe and stay unchanged for the whole request.

The completion flag from the PLL falls in step with the scan clock but rises asynchronously. It therefore enters through a multi-stage synchronizer, and every decision is taken on the synchronized copy. The requesting logic sees a busy level for the duration of the request, a one-cycle done pulse at its end, and a one-cycle error pulse when a request arrives while a previous one is still running. A step count of zero completes immediately.

Top module: `phase_step_seq`

## Requirements
- R1: The request word is decoded as step count in bits [15:0], counter select in bits [20:16] and direction in bit [21]. At every rising edge of `ps_en`, `ps_sel` equals the select field and `ps_updn` equals the direction bit (1 = positive shift, 0 = negative shift).
- R2: Every select value is passed through unchanged, including 0 to 17 (output counters), 18 (feedback counter) and 31 (all output counters together).
- R3: A request with a non-zero step count N produces exactly N rising edges of `ps_en`.
- R4: Each `ps_en` high period lasts at least MIN_EN_CYC cycles, and `ps_en` falls only after the synchronized completion flag has been seen low during that period.
- R5: `ps_en` rises only while the synchronized completion flag is high, so a new step begins only after the flag has returned from low to high.
- R6: `ps_sel` and `ps_updn` are set one cycle before the first `ps_en` rise and stay stable for as long as `busy` is high.
- R7: A request with a step count of zero raises `done` in the cycle after acceptance, leaves `busy` low and produces no `ps_en` pulse.
- R8: A request presented while `busy` is high is ignored; `err` is high for one cycle after it, and the running request keeps its select, direction and pulse count.
- R9: `busy` rises in the cycle after a non-zero request is accepted and stays high until the end of the last step. `done` is a one-cycle pulse in the first cycle in which `busy` is low again.
- R10: After reset, `busy`, `done`, `err` and `ps_en` are low.
- R11: The completion flag passes through SYNC_STAGES flops, and a low period of any length of one scan-clock cycle or more is recognized as a completed step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Scan clock; all logic is on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, sampled for one cycle |
| req_word | input | CNT_W+SEL_W+1 | Request: direction, select, step count |
| busy | output | 1 | A request is being sequenced |
| done | output | 1 | One-cycle pulse at request completion |
| err | output | 1 | One-cycle pulse for a request rejected while busy |
| ps_en | output | 1 | Phase-step enable toward the PLL |
| ps_sel | output | SEL_W | Counter select toward the PLL |
| ps_updn | output | 1 | Shift direction toward the PLL |
| ps_done_async | input | 1 | Step-complete flag from the PLL, asynchronous rise |

## Verification
A table of requests is walked against a PLL model whose completion flag stays low for one to four cycles and rises a few nanoseconds after an edge. The table mixes step counts from 1 to 16, both directions and the select values for a plain output counter, the last output counter, the feedback counter and the all-counters code. The short low times show whether a step is counted when the flag is back high before the strobe falls. The long ones show that the strobe is held until the flag drops and never re-raised early. Directed cases cover a zero count, which must finish without a strobe, and a second request during a running one, which must be flagged and must not disturb the pulse count or the select.

// File: rtl/pss_pkg.sv
`timescale 1ns/1ps
package pss_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SETUP = 2'd1,
      ST_PULSE = 2'd2,
      ST_WAIT  = 2'd3
   } pss_state_e;
endpackage

// File: rtl/pss_sync.sv
`timescale 1ns/1ps
module pss_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pss_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d_async};
   end

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/pss_hold_timer.sv
`timescale 1ns/1ps
module pss_hold_timer #(
   parameter int MIN_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic met
);
   generate
      if (MIN_CYC < 1) begin : g_bad_min
         $error("pss_hold_timer: MIN_CYC must be at least 1");
      end
      if (MIN_CYC == 1) begin : g_trivial
         assign met = run;
      end else begin : g_count
         localparam int TW = $clog2(MIN_CYC);
         localparam logic [TW-1:0] LAST = TW'(MIN_CYC - 1);
         logic [TW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n || !run) cnt <= '0;
            else if (cnt != LAST) cnt <= cnt + 1'b1;
         end
         assign met = run && (cnt == LAST);
      end
   endgenerate
endmodule

// File: rtl/pss_step_fsm.sv
`timescale 1ns/1ps
module pss_step_fsm
   import pss_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter int SEL_W      = 5,
   parameter int MIN_EN_CYC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [CNT_W-1:0] req_cnt,
   input  logic [SEL_W-1:0] req_sel,
   input  logic             req_dir,
   input  logic             done_s,
   output logic             busy,
   output logic             done,
   output logic             err,
   output logic             ps_en,
   output logic [SEL_W-1:0] ps_sel,
   output logic             ps_updn
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   pss_state_e       state;
   logic [CNT_W-1:0] remain;
   logic [SEL_W-1:0] sel_q;
   logic             dir_q;
   logic             low_seen;
   logic             done_q;
   logic             err_q;
   logic             hold_met;

   pss_hold_timer #(.MIN_CYC(MIN_EN_CYC)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (state == ST_PULSE),
      .met   (hold_met)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         remain   <= '0;
         sel_q    <= '0;
         dir_q    <= 1'b0;
         low_seen <= 1'b0;
         done_q   <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= req_valid && (state != ST_IDLE);
         unique case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  if (req_cnt == '0) begin
                     done_q <= 1'b1;
                  end else begin
                     remain <= req_cnt;
                     sel_q  <= req_sel;
                     dir_q  <= req_dir;
                     state  <= ST_SETUP;
                  end
               end
            end
            ST_SETUP: begin
               low_seen <= 1'b0;
               state    <= ST_PULSE;
            end
            ST_PULSE: begin
               if (!done_s) low_seen <= 1'b1;
               if (hold_met && (low_seen || !done_s)) state <= ST_WAIT;
            end
            ST_WAIT: begin
               if (done_s) begin
                  low_seen <= 1'b0;
                  if (remain == ONE) begin
                     done_q <= 1'b1;
                     state  <= ST_IDLE;
                  end else begin
                     remain <= remain - ONE;
                     state  <= ST_PULSE;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy    = (state != ST_IDLE);
   assign done    = done_q;
   assign err     = err_q;
   assign ps_en   = (state == ST_PULSE);
   assign ps_sel  = sel_q;
   assign ps_updn = dir_q;
endmodule

// File: rtl/phase_step_seq.sv
`timescale 1ns/1ps
module phase_step_seq #(
   parameter int CNT_W       = 16,
   parameter int SEL_W       = 5,
   parameter int MIN_EN_CYC  = 2,
   parameter int SYNC_STAGES = 2,
   localparam int REQ_W      = CNT_W + SEL_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [REQ_W-1:0] req_word,
   output logic             busy,
   output logic             done,
   output logic             err,
   output logic             ps_en,
   output logic [SEL_W-1:0] ps_sel,
   output logic             ps_updn,
   input  logic             ps_done_async
);
   generate
      if (CNT_W < 1 || SEL_W < 1) begin : g_bad_width
         $error("phase_step_seq: field widths must be positive");
      end
   endgenerate

   localparam int SEL_LO = CNT_W;
   localparam int DIR_B  = CNT_W + SEL_W;

   logic done_sync;

   pss_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (ps_done_async),
      .q_sync  (done_sync)
   );

   pss_step_fsm #(
      .CNT_W      (CNT_W),
      .SEL_W      (SEL_W),
      .MIN_EN_CYC (MIN_EN_CYC)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_cnt   (req_word[CNT_W-1:0]),
      .req_sel   (req_word[SEL_LO +: SEL_W]),
      .req_dir   (req_word[DIR_B]),
      .done_s    (done_sync),
      .busy      (busy),
      .done      (done),
      .err       (err),
      .ps_en     (ps_en),
      .ps_sel    (ps_sel),
      .ps_updn   (ps_updn)
   );
endmodule

// File: rtl/pss_checker.sv
`timescale 1ns/1ps
module pss_checker #(
   parameter int SEL_W      = 5,
   parameter int MIN_EN_CYC = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             busy,
   input logic             done,
   input logic             err,
   input logic             ps_en,
   input logic [SEL_W-1:0] ps_sel,
   input logic             ps_updn,
   input logic             done_s
);
   localparam int RW = $clog2(MIN_EN_CYC + 1) + 1;
   localparam logic [RW-1:0] RMAX = RW'(MIN_EN_CYC);

   logic [RW-1:0] en_run;
   logic          low_seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_run   <= '0;
         low_seen <= 1'b0;
      end else begin
         if (!ps_en)            en_run <= '0;
         else if (en_run != RMAX) en_run <= en_run + 1'b1;
         if (!ps_en)            low_seen <= 1'b0;
         else if (!done_s)      low_seen <= 1'b1;
      end
   end

   AST_EN_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ps_en && en_run != '0) |-> (en_run >= RMAX));                          // R4
   AST_EN_FALL_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ps_en) |-> (low_seen || $past(!done_s)));                          // R4
   AST_EN_RISE_DONE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ps_en) |-> done_s);                                                // R5
   AST_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(ps_sel) && $stable(ps_updn)));        // R6
   AST_ERR_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> ($past(busy) && $past(req_valid)));                              // R8
   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);                                                         // R9
   AST_IDLE_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !ps_en);                                                       // R9
endmodule

bind phase_step_seq pss_checker #(
   .SEL_W      (SEL_W),
   .MIN_EN_CYC (MIN_EN_CYC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .busy      (busy),
   .done      (done),
   .err       (err),
   .ps_en     (ps_en),
   .ps_sel    (ps_sel),
   .ps_updn   (ps_updn),
   .done_s    (done_sync)
);

// File: tb/phase_step_seq_tb.sv
`timescale 1ns/1ps
module phase_step_seq_tb;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_W = 16;
   localparam int SEL_W = 5;
   localparam int MIN_EN = 2;
   localparam int REQ_W = CNT_W + SEL_W + 1;
   localparam int NVEC = 6;

   // {low cycles[3:0], dir, sel[4:0], count[15:0]}
   localparam logic [25:0] VEC [NVEC] = '{
      {4'd1, 1'b1, 5'd0,  16'd1},
      {4'd2, 1'b0, 5'd5,  16'd3},
      {4'd4, 1'b1, 5'd17, 16'd4},
      {4'd1, 1'b0, 5'd18, 16'd2},
      {4'd3, 1'b1, 5'd31, 16'd5},
      {4'd1, 1'b0, 5'd9,  16'd16}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_valid = 1'b0;
   logic [REQ_W-1:0] req_word = '0;
   logic             busy, done, err, ps_en, ps_updn;
   logic [SEL_W-1:0] ps_sel;
   logic             ps_done_async = 1'b1;

   int checks = 0;
   int errors = 0;
   int n_pulse = 0;
   int bad_field = 0;
   int bad_width = 0;
   int bad_order = 0;
   int low_cyc = 1;
   logic [SEL_W-1:0] exp_sel = '0;
   logic             exp_dir = 1'b0;
   logic             drop_flag = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   phase_step_seq #(.CNT_W(CNT_W), .SEL_W(SEL_W), .MIN_EN_CYC(MIN_EN)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_word(req_word),
      .busy(busy), .done(done), .err(err), .ps_en(ps_en), .ps_sel(ps_sel),
      .ps_updn(ps_updn), .ps_done_async(ps_done_async)
   );

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // PLL responder: drop flag after enable rises, hold low, rise off-edge
   initial begin
      logic en_prev;
      en_prev = 1'b0;
      forever begin
         @(posedge clk); #1;
         if (ps_en && !en_prev) begin
            n_pulse++;
            drop_flag = 1'b0;
            if (ps_sel !== exp_sel || ps_updn !== exp_dir) bad_field++;
            @(posedge clk); #1;
            ps_done_async = 1'b0;
            drop_flag = 1'b1;
            repeat (low_cyc) @(posedge clk);
            #3 ps_done_async = 1'b1;
         end
         en_prev = ps_en;
      end
   end

   // Enable width and release-order monitor
   initial begin
      int run;
      logic prev;
      run = 0; prev = 1'b0;
      forever begin
         @(posedge clk); #1;
         if (ps_en) run++;
         else if (prev) begin
            if (run < MIN_EN) bad_width++;
            if (!drop_flag) bad_order++;
            run = 0;
         end
         prev = ps_en;
      end
   end

   task automatic send(input logic [REQ_W-1:0] w);
      @(posedge clk); #1;
      req_valid = 1'b1; req_word = w;
      @(posedge clk); #1;
      req_valid = 1'b0;
   endtask

   task automatic wait_done(output logic seen);
      seen = 1'b0;
      for (int i = 0; i < 3000; i++) begin
         if (done) begin seen = 1'b1; break; end
         @(posedge clk); #1;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic seen;
      repeat (3) @(posedge clk); #1;
      // R10 reset state
      chk(!busy && !done && !err && !ps_en, "R10 reset outputs",
          {busy, done, err, ps_en}, 0);
      rst_n = 1'b1;

      for (int v = 0; v < NVEC; v++) begin
         logic [15:0] cnt;
         cnt       = VEC[v][15:0];
         exp_sel   = VEC[v][20:16];
         exp_dir   = VEC[v][21];
         low_cyc   = int'(VEC[v][25:22]);
         n_pulse = 0; bad_field = 0; bad_width = 0; bad_order = 0;
         send(VEC[v][21:0]);
         chk(busy && !err, "R9 busy after accept", busy, 1);
         wait_done(seen);
         chk(seen && !busy, "R9 done with busy low", {seen, busy}, 2);
         @(posedge clk); #1;
         chk(!done, "R9 done single cycle", done, 0);
         chk(n_pulse == int'(cnt), "R3 pulse count (R11 low time)", n_pulse, int'(cnt));
         chk(bad_field == 0, "R1 R2 select/direction at enable rise", bad_field, 0);
         chk(bad_width == 0 && bad_order == 0, "R4 enable hold and release",
             bad_width + bad_order, 0);
         chk(!ps_en && ps_sel == exp_sel && ps_updn == exp_dir,
             "R6 select held after request", ps_sel, exp_sel);
      end

      // R7 zero step count
      n_pulse = 0;
      send({1'b1, 5'd3, 16'd0});
      chk(done && !busy, "R7 zero count done at once", {done, busy}, 2);
      repeat (6) @(posedge clk); #1;
      chk(n_pulse == 0 && !busy, "R7 zero count no pulse", n_pulse, 0);

      // R8 request while busy is rejected
      exp_sel = 5'd2; exp_dir = 1'b1; low_cyc = 2;
      n_pulse = 0; bad_field = 0;
      send({1'b1, 5'd2, 16'd3});
      chk(!err, "R8 no error on accepted request", err, 0);
      send({1'b0, 5'd12, 16'd7});
      chk(err, "R8 error pulse on busy request", err, 1);
      chk(ps_sel == 5'd2 && ps_updn, "R8 select unchanged by rejected request", ps_sel, 2);
      @(posedge clk); #1;
      chk(!err, "R8 error single cycle", err, 0);
      wait_done(seen);
      chk(seen && n_pulse == 3 && bad_field == 0, "R8 running request intact", n_pulse, 3);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule